// File: doc/BRIEF.md
# Three-Wire Handshake Packet Receiver

This block is the host end of a three-wire serial link when the attached guest device transmits. The guest owns the clock wire and the host owns the acknowledge wire. Each step of a transfer is a toggle on one wire answered by a toggle on the other. The engine watches for the guest pulling its clock low. If the host is willing, it lowers acknowledge. It then checks on the next rising clock whether the guest has committed to the transfer or backed out.

Once a transfer is committed, every clock toggle presents one data bit. The engine samples the bit and toggles acknowledge in reply. Bits are packed least significant first into bytes. The first byte is a header: one bit in it must be set, and its low bits give the number of payload bytes that follow. The header and the payload are delivered on a valid/last byte stream. A closing pair of clock edges carries a parity bit and a stop bit. Four sticky flags report an abort, a bad header, a parity mismatch and a missing stop bit.

All link inputs are taken to be already synchronous to `clk`. The engine compares each link clock sample with the previous one to find edges.

Top module: `tw_rx`

## Requirements
- R1: After reset, link_ack_o is 1, byte_valid_o and byte_last_o are 0, and all four error flags are 0.
- R2: In idle, a falling link_clk_i drives link_ack_o to 0 when rx_en_i is 1. When rx_en_i is 0, the fall is ignored and link_ack_o stays 1.
- R3: After the host agrees, the next rising link_clk_i raises link_ack_o. If link_data_i is 1 at that edge, err_abort_o is set, no byte is delivered and the engine returns to idle. If link_data_i is 0, the data phase starts.
- R4: In the data phase, every edge of link_clk_i samples link_data_i and inverts link_ack_o. Bits fill each byte starting at bit 0.
- R5: If header bit 3 is 0, err_format_o is set, the header is not delivered, and the engine returns to idle with link_ack_o at 1.
- R6: Header bits 2:0 give N, the number of payload bytes (0 to 7). The header and then N payload bytes appear on byte_o, each with a one-cycle byte_valid_o pulse. byte_last_o is 1 only on the final byte, which is the header itself when N is 0. No further byte is accepted.
- R7: After the final byte, the next falling link_clk_i carries the parity bit. The expected bit is the XOR of all received bits, header included (1 when the count of ones is odd). A mismatch sets err_parity_o. link_ack_o goes to 0 in either case.
- R8: The following rising link_clk_i carries the stop bit. A 0 sets err_frame_o. link_ack_o returns to 1 and the engine goes idle.
- R9: The error flags are sticky until reset, and later packets are still received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en_i | input | 1 | Host willing to accept a packet |
| link_clk_i | input | 1 | Guest-driven link clock |
| link_data_i | input | 1 | Guest-driven link data |
| link_ack_o | output | 1 | Host acknowledge wire |
| byte_o | output | 8 | Received byte |
| byte_valid_o | output | 1 | byte_o valid for one cycle |
| byte_last_o | output | 1 | Final byte of the packet |
| err_abort_o | output | 1 | Sticky: guest aborted before data |
| err_format_o | output | 1 | Sticky: header format bit clear |
| err_parity_o | output | 1 | Sticky: parity mismatch |
| err_frame_o | output | 1 | Sticky: stop bit was 0 |

## Verification
The assertions assume that the link clock is high while reset is held. They also assume the guest never changes the link clock more often than once per system clock. Under these assumptions, an unchanged clock sample means no acknowledge movement is allowed.

The stimulus behaves as a well-paced guest. It changes the link clock and data together on the falling system clock edge and then waits several cycles before the next change. At every step it also checks that the acknowledge wire has moved to the value the protocol expects.

// File: rtl/tw_rx.sv
module tw_rx #(
  parameter int BYTE_W  = 8,
  parameter int LEN_W   = 3,
  parameter int FMT_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en_i,
  input  logic              link_clk_i,
  input  logic              link_data_i,
  output logic              link_ack_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              byte_last_o,
  output logic              err_abort_o,
  output logic              err_format_o,
  output logic              err_parity_o,
  output logic              err_frame_o
);
  localparam int BC_W = $clog2(BYTE_W);
  localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

  typedef enum logic [2:0] {S_IDLE, S_COMMIT, S_BITS, S_PAR, S_STOP} st_t;

  st_t               st;
  logic              clk_q, par, hdr;
  logic [BC_W-1:0]   bitn;
  logic [LEN_W-1:0]  left;
  logic [BYTE_W-1:0] sh;

  wire fall = clk_q & ~link_clk_i;
  wire rise = ~clk_q & link_clk_i;
  wire [BYTE_W-1:0] nsh = {link_data_i, sh[BYTE_W-1:1]};

  assign byte_o = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      clk_q <= 1'b1;
      link_ack_o <= 1'b1;
      sh <= '0;
      bitn <= '0;
      left <= '0;
      hdr <= 1'b0;
      par <= 1'b0;
      byte_valid_o <= 1'b0;
      byte_last_o <= 1'b0;
      err_abort_o <= 1'b0;
      err_format_o <= 1'b0;
      err_parity_o <= 1'b0;
      err_frame_o <= 1'b0;
    end else begin
      clk_q <= link_clk_i;
      byte_valid_o <= 1'b0;
      byte_last_o <= 1'b0;
      case (st)
        S_IDLE: if (fall && rx_en_i) begin
          link_ack_o <= 1'b0;
          st <= S_COMMIT;
        end
        S_COMMIT: if (rise) begin
          link_ack_o <= 1'b1;
          if (!link_data_i) begin
            st <= S_BITS;
            bitn <= '0;
            hdr <= 1'b1;
            par <= 1'b0;
          end else begin
            err_abort_o <= 1'b1;
            st <= S_IDLE;
          end
        end
        S_BITS: if (fall || rise) begin
          link_ack_o <= ~link_ack_o;
          sh <= nsh;
          par <= par ^ link_data_i;
          bitn <= bitn + 1'b1;
          if (bitn == LAST_BIT) begin
            if (hdr) begin
              hdr <= 1'b0;
              if (!nsh[FMT_BIT]) begin
                err_format_o <= 1'b1;
                st <= S_IDLE;
              end else begin
                byte_valid_o <= 1'b1;
                byte_last_o <= (nsh[LEN_W-1:0] == '0);
                left <= nsh[LEN_W-1:0];
                if (nsh[LEN_W-1:0] == '0) st <= S_PAR;
              end
            end else begin
              byte_valid_o <= 1'b1;
              byte_last_o <= (left == LEN_W'(1));
              left <= left - 1'b1;
              if (left == LEN_W'(1)) st <= S_PAR;
            end
          end
        end
        S_PAR: if (fall) begin
          if (link_data_i != par) err_parity_o <= 1'b1;
          link_ack_o <= 1'b0;
          st <= S_STOP;
        end
        S_STOP: if (rise) begin
          if (!link_data_i) err_frame_o <= 1'b1;
          link_ack_o <= 1'b1;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tw_rx_checker.sv
module tw_rx_checker (
  input logic clk,
  input logic rst_n,
  input logic link_clk_i,
  input logic link_ack_o,
  input logic byte_valid_o,
  input logic byte_last_o,
  input logic err_abort_o,
  input logic err_format_o,
  input logic err_parity_o,
  input logic err_frame_o
);
  p_ack_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (link_clk_i == $past(link_clk_i)) |=> $stable(link_ack_o));

  p_last_with_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_last_o |-> byte_valid_o);

  p_valid_ack_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid_o |-> link_ack_o);

  p_abort_ack_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_abort_o) |-> link_ack_o && !byte_valid_o);

  p_format_no_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_format_o) |-> !byte_valid_o && link_ack_o);

  p_parity_ack_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_parity_o) |-> !link_ack_o);

  p_frame_ack_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_frame_o) |-> link_ack_o);

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    {err_abort_o, err_format_o, err_parity_o, err_frame_o} ==
    ({err_abort_o, err_format_o, err_parity_o, err_frame_o} |
     $past({err_abort_o, err_format_o, err_parity_o, err_frame_o})));
endmodule

bind tw_rx tw_rx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .link_clk_i(link_clk_i), .link_ack_o(link_ack_o),
  .byte_valid_o(byte_valid_o), .byte_last_o(byte_last_o),
  .err_abort_o(err_abort_o), .err_format_o(err_format_o),
  .err_parity_o(err_parity_o), .err_frame_o(err_frame_o)
);

// File: tb/tw_rx_tb.sv
module tw_rx_tb;
  localparam int PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, rx_en = 1'b1, lclk = 1'b1, ldata = 1'b1;
  logic ack, vld, last, e_ab, e_fm, e_pa, e_fr;
  logic [7:0] b;
  int n_run = 0, n_fail = 0;
  logic [3:0] exp_err = 4'b0;

  logic [7:0] rx_b [64];
  int rx_n = 0, last_idx = -1;

  always #(PERIOD/2) clk = ~clk;

  tw_rx u_dut (
    .clk(clk), .rst_n(rst_n), .rx_en_i(rx_en), .link_clk_i(lclk), .link_data_i(ldata),
    .link_ack_o(ack), .byte_o(b), .byte_valid_o(vld), .byte_last_o(last),
    .err_abort_o(e_ab), .err_format_o(e_fm), .err_parity_o(e_pa), .err_frame_o(e_fr)
  );

  always @(negedge clk) if (vld && rx_n < 64) begin
    rx_b[rx_n] <= b;
    if (last) last_idx <= rx_n;
    rx_n <= rx_n + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic d);
    @(negedge clk);
    lclk = c;
    ldata = d;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [3:0] errs();
    return {e_ab, e_fm, e_pa, e_fr};
  endfunction

  // R2, R3, R4, R6, R7, R8: one full packet with chosen parity and stop bit
  task automatic send_pkt(input logic [7:0] hdr, input logic [55:0] pl,
                          input logic bad_par, input logic stop_bit);
    int base = rx_n;
    int n = hdr[2:0];
    int ack_bad = 0;
    logic p = ^hdr;
    logic exp_ack = 1'b1;
    step(1'b0, 1'b1);
    chk("R2 ack low on clk fall", ack, 1'b0);
    step(1'b1, 1'b0);
    chk("R3 ack high on commit", ack, 1'b1);
    for (int i = 0; i <= n; i++) begin
      logic [7:0] by = (i == 0) ? hdr : pl[8*(i-1) +: 8];
      if (i > 0) p = p ^ (^by);
      for (int k = 0; k < 8; k++) begin
        step(~lclk, by[k]);
        exp_ack = ~exp_ack;
        if (ack !== exp_ack) ack_bad++;
      end
    end
    chk("R4 ack toggles per bit", ack_bad, 0);
    step(1'b0, p ^ bad_par);
    chk("R7 ack low after parity", ack, 1'b0);
    step(1'b1, stop_bit);
    chk("R8 ack high after stop", ack, 1'b1);
    chk("R6 byte count", rx_n - base, n + 1);
    chk("R4 header byte lsb first", rx_b[base], hdr);
    for (int i = 1; i <= n; i++)
      chk("R6 payload byte", rx_b[base + i], pl[8*(i-1) +: 8]);
    chk("R6 last on final byte", last_idx, base + n);
    if (bad_par) exp_err[1] = 1'b1;
    if (!stop_bit) exp_err[0] = 1'b1;
    chk("R7 R8 R9 error flags", errs(), exp_err);
  endtask

  task automatic t_reset();
    chk("R1 ack high", ack, 1'b1);
    chk("R1 no valid", {vld, last}, 2'b00);
    chk("R1 flags clear", errs(), 4'b0);
  endtask

  task automatic t_unwilling();
    rx_en = 1'b0;
    step(1'b0, 1'b1);
    chk("R2 ack stays high when unwilling", ack, 1'b1);
    step(1'b1, 1'b1);
    rx_en = 1'b1;
    chk("R2 no flags when unwilling", errs(), exp_err);
  endtask

  task automatic t_abort();
    int base = rx_n;
    step(1'b0, 1'b1);
    chk("R2 ack low", ack, 1'b0);
    step(1'b1, 1'b1);
    exp_err[3] = 1'b1;
    chk("R3 ack high after abort", ack, 1'b1);
    chk("R3 abort flag", errs(), exp_err);
    chk("R3 no bytes on abort", rx_n - base, 0);
  endtask

  task automatic t_format();
    int base = rx_n;
    logic [7:0] h = 8'h52;
    step(1'b0, 1'b1);
    step(1'b1, 1'b0);
    for (int k = 0; k < 8; k++) step(~lclk, h[k]);
    exp_err[2] = 1'b1;
    chk("R5 format flag", errs(), exp_err);
    chk("R5 header not delivered", rx_n - base, 0);
    chk("R5 ack high in idle", ack, 1'b1);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_unwilling();
    send_pkt(8'h08, 56'h0, 1'b0, 1'b1);
    send_pkt(8'h5B, 56'h00_0000_00C3_7E01, 1'b0, 1'b1);
    send_pkt(8'h0F, 56'hF0_0F55_AA12_3481, 1'b0, 1'b1);
    t_abort();
    send_pkt(8'h0A, 56'h0000_0000_0000_FF80, 1'b1, 1'b1);
    send_pkt(8'h09, 56'h0000_0000_0000_0033, 1'b0, 1'b0);
    t_format();
    send_pkt(8'h1A, 56'h0000_0000_0000_6502, 1'b0, 1'b1); // R9 flags kept, packet still received
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule